// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external host read and write a bank of 32-bit registers over a four-wire serial link. The host lowers the active-low select, then shifts in, most significant bit first, an 8-bit instruction, an 8-bit register address and one or more 32-bit data words. The address names one 32-bit register, as bits 9 down to 2 of a byte address. One select window can carry a burst of words. The instruction chooses whether the register address goes up, goes down or stays fixed between words, and the address wraps around at both ends.

The serial pins are sampled by the block's own clock through synchronizers. SI is taken on each rising SCK edge and SO is updated after each falling edge, so SCK may idle low (mode 0) or high (mode 3). Each SCK high and low phase must last at least 6 `clk` cycles. On the register side there are plain strobes with no back-pressure: the bank must accept a write pulse in any cycle and must return read data on `rd_data` one `clk` cycle after `rd_en`.

Until `reset_done` is high, every read returns a fixed invalid word. After that, one test address returns a known constant, so the host can poll it to learn that the link works.

Top module: `spi_regport`

## Requirements
- R1: A transaction starts when `cs_n` falls. The first 8 SI bits form the instruction and the next 8 bits form the register address. Data words follow. Every field is sent most significant bit first, and SI is sampled on rising SCK edges.
- R2: In a read, SO carries D31 first, then D30 down to D0, and changes only after falling SCK edges. `so_oe` is 0 during the instruction and address fields and while `cs_n` is high. It is 1 during the data bits of a read.
- R3: The read instructions are 0x03 (address fixed), 0x07 (increment) and 0x0B (decrement). Instruction bit 2 requests increment and bit 3 requests decrement. Each further 32-bit word in the same select window comes from the stepped address.
- R4: The write instructions are 0x02 (fixed), 0x06 (increment) and 0x0A (decrement). Each complete 32-bit word gives exactly one `wr_en` pulse, with the word on `wr_data` and its register address on `wr_addr`. The address then steps as the instruction directs.
- R5: Incrementing from address 0xFF gives 0x00, and decrementing from 0x00 gives 0xFF.
- R6: If `cs_n` rises before all 32 bits of a data word have arrived, that word gives no `wr_en` pulse and the register stays unchanged. Earlier complete words of the burst are still written.
- R7: `so_oe` stays 0 for the whole of a write transaction.
- R8: While `reset_done` is 0, every read returns 0xFFFFFFFF. Once it is 1, address 0x1F reads 0x5A3C96E1 whatever the bank holds, and all other addresses read the bank.
- R9: Any other instruction value makes the block ignore the rest of that select window. It gives no `wr_en`, no `rd_en` and no SO drive.
- R10: Transactions give the same results whether SCK idles low or idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data from the host |
| reset_done | input | 1 | High once the device has finished its reset |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for SO; 0 means high-impedance |
| rd_en | output | 1 | One-cycle register read request |
| rd_addr | output | 8 | Register address of the read request |
| rd_data | input | 32 | Bank read data, valid one cycle after rd_en |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 32 | Word to be written |

## Verification
Writes and reads are tried with each of the three address modes. Fixed-mode bursts show that the address is held, because only the last word survives and repeated reads return it. Increment and decrement bursts that start next to 0xFF and 0x00 tell correct wrapping apart from saturation or an off-by-one step. A write cut off after 20 data bits, an unknown instruction, and reads before and after `reset_done` show that data is dropped, ignored or replaced only where it should be. Reads and writes in both SCK idle levels check the edge choice.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {OPK_NONE, OPK_RD, OPK_WR} op_kind_t;
  typedef enum logic [1:0] {DIR_HOLD, DIR_INC, DIR_DEC} step_dir_t;
  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_t;

  typedef struct packed {
    op_kind_t  kind;
    step_dir_t dir;
  } op_t;

  localparam int unsigned INSTR_W = 8;

  // bits 7:4 zero, bit 1 set; bit 0 picks read; bits 3:2 pick the step
  function automatic op_t decode_op(input logic [INSTR_W-1:0] ins);
    op_t o;
    o.kind = OPK_NONE;
    o.dir  = DIR_HOLD;
    if (ins[7:4] == 4'b0000 && ins[1]) begin
      o.kind = ins[0] ? OPK_RD : OPK_WR;
      case (ins[3:2])
        2'b00:   o.dir = DIR_HOLD;
        2'b01:   o.dir = DIR_INC;
        2'b10:   o.dir = DIR_DEC;
        default: o.kind = OPK_NONE;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              si_bit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_req,
  output logic              rd_mode
);
  localparam int unsigned MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int unsigned CNT_W = $clog2(MAXF);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] sr;
  logic [ADDR_W-1:0] addr_q;
  op_t               op_q, op_new;
  logic              rd_pend;
  logic [DATA_W-1:0] word_in;

  assign word_in = {sr, si_bit};
  assign op_new  = decode_op(word_in[INSTR_W-1:0]);

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input step_dir_t d);
    case (d)
      DIR_INC: return a + ONE;
      DIR_DEC: return a - ONE;
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_CMD;
      cnt      <= '0;
      sr       <= '0;
      addr_q   <= '0;
      op_q     <= '{kind: OPK_NONE, dir: DIR_HOLD};
      rd_pend  <= 1'b0;
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      load_req <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      rd_en    <= 1'b0;
      load_req <= 1'b0;
      if (rd_pend) begin
        rd_en   <= 1'b1;
        rd_pend <= 1'b0;
      end
      if (!cs_act) begin
        ph      <= PH_CMD;
        cnt     <= '0;
        rd_pend <= 1'b0;
        op_q    <= '{kind: OPK_NONE, dir: DIR_HOLD};
      end else if (sck_rise) begin
        sr  <= word_in[DATA_W-2:0];
        cnt <= cnt + 1'b1;
        case (ph)
          PH_CMD: if (cnt == CMD_LAST) begin
            cnt  <= '0;
            op_q <= op_new;
            ph   <= (op_new.kind == OPK_NONE) ? PH_SKIP : PH_ADDR;
          end
          PH_ADDR: if (cnt == ADDR_LAST) begin
            cnt    <= '0;
            addr_q <= word_in[ADDR_W-1:0];
            ph     <= PH_DATA;
            if (op_q.kind == OPK_RD) begin
              rd_pend  <= 1'b1;
              load_req <= 1'b1;
            end
          end
          PH_DATA: if (cnt == DATA_LAST) begin
            cnt    <= '0;
            addr_q <= step(addr_q, op_q.dir);
            if (op_q.kind == OPK_WR) begin
              wr_en   <= 1'b1;
              wr_addr <= addr_q;
              wr_data <= word_in;
            end else begin
              rd_pend  <= 1'b1;
              load_req <= 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign rd_addr = addr_q;
  assign rd_mode = (op_q.kind == OPK_RD);

  // R4: a write strobe and a read request never share a cycle
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));

  // R9: an ignored transaction issues no bank access
  a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SKIP) |=> (!wr_en && !rd_en));

  // R6: a write strobe only follows a rising SCK seen while selected
  a_r6_wr_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sck_rise && cs_act));
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              load_req,
  input  logic              fetch_vld,
  input  logic [DATA_W-1:0] fetch_word,
  output logic              so,
  output logic              so_oe
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      armed  <= 1'b0;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else if (!cs_act) begin
      armed <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      if (fetch_vld) hold_q <= fetch_word;
      if (sck_fall) begin
        if (armed) begin
          so    <= hold_q[DATA_W-1];
          sh_q  <= {hold_q[DATA_W-2:0], 1'b0};
          so_oe <= 1'b1;
          armed <= 1'b0;
        end else if (so_oe) begin
          so   <= sh_q[DATA_W-1];
          sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
      end
      if (load_req) armed <= 1'b1;
    end
  end

  // R2: SO only moves after a falling SCK edge
  a_r2_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so));

  // R2: the driver turns on only for a word that was requested
  a_r2_oe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(armed));
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [ADDR_W-1:0] TEST_ADDR    = 8'h1F,
  parameter logic [DATA_W-1:0] TEST_PATTERN = 32'h5A3C_96E1,
  parameter logic [DATA_W-1:0] INVALID_WORD = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              reset_done,
  output logic              so,
  output logic              so_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0]        pins_s;
  logic              cs_act, sck_s, si_s, sck_prev;
  logic              sck_rise, sck_fall;
  logic              load_req, rd_mode, fetch_vld;
  logic [DATA_W-1:0] fetch_word;

  spi_regport_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
  );

  assign cs_act = !pins_s[2];
  assign sck_s  = pins_s[1];
  assign si_s   = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev  <= 1'b0;
      fetch_vld <= 1'b0;
    end else begin
      sck_prev  <= sck_s;
      fetch_vld <= rd_en;
    end
  end

  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  always_comb begin
    if (!reset_done)              fetch_word = INVALID_WORD;
    else if (rd_addr == TEST_ADDR) fetch_word = TEST_PATTERN;
    else                          fetch_word = rd_data;
  end

  spi_regport_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .si_bit(si_s), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_req(load_req),
    .rd_mode(rd_mode)
  );

  spi_regport_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .load_req(load_req), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
    .so(so), .so_oe(so_oe)
  );

  // R2: the driver releases SO once the select is seen high
  a_r2_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

  // R7: SO is never driven outside a read transaction
  a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> rd_mode);
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [31:0] INVALID = 32'hFFFF_FFFF;
  localparam logic [31:0] PATTERN = 32'h5A3C_96E1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, reset_done = 1'b0;
  logic so, so_oe, rd_en, wr_en;
  logic [7:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .reset_done(reset_done), .so(so), .so_oe(so_oe), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [31:0] mem [256];
  logic [31:0] expm [256];
  int wr_cnt = 0, rd_cnt = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = (i * 32'h0101_0101) ^ 32'h1357_9BDF;

  always @(posedge clk) begin
    if (wr_en) begin mem[wr_addr] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (rd_en) begin rd_data <= mem[rd_addr]; rd_cnt <= rd_cnt + 1; end
  end

  int checks = 0, errors = 0;
  logic [31:0] wbuf [8];
  logic [31:0] rbuf [8];
  int hdr_oe, data_oe_lo, data_oe_hi;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    @(negedge clk);
    sck = 1'b0; si = b;
    repeat (HALF) @(negedge clk);
    r = so; oe = so_oe;
    sck = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic spi_txn(input bit m3, input logic [7:0] op, input logic [7:0] a,
                         input int nwords, input int extra);
    logic r, oe;
    logic [15:0] hdr;
    hdr_oe = 0; data_oe_lo = 0; data_oe_hi = 0;
    hdr = {op, a};
    @(negedge clk); sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      spi_bit(hdr[i], r, oe);
      if (oe) hdr_oe++;
    end
    for (int w = 0; w < nwords; w++)
      for (int i = 31; i >= 0; i--) begin
        spi_bit(wbuf[w][i], r, oe);
        rbuf[w][i] = r;
        if (oe) data_oe_hi++; else data_oe_lo++;
      end
    for (int i = 0; i < extra; i++) begin
      spi_bit(wbuf[nwords][31-i], r, oe);
      if (oe) data_oe_hi++;
    end
    @(negedge clk); sck = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read1(input bit m3, input logic [7:0] a, output logic [31:0] d);
    wbuf[0] = '0;
    spi_txn(m3, 8'h03, a, 1, 0);
    d = rbuf[0];
  endtask

  task automatic t_reset;
    check("R2 reset so_oe", {31'b0, so_oe}, 0);
    check("R4 reset wr_en", {31'b0, wr_en}, 0);
    check("R9 reset rd_en", {31'b0, rd_en}, 0);
  endtask

  task automatic t_not_ready;
    logic [31:0] d;
    read1(1'b0, 8'h1F, d);
    check("R8 test addr before done", d, INVALID);
    read1(1'b0, 8'h05, d);
    check("R8 bank addr before done", d, INVALID);
    check("R2 oe low in header", hdr_oe, 0);
    check("R2 oe high in data", data_oe_lo, 0);
    check("R2 oe low after cs rise", {31'b0, so_oe}, 0);
  endtask

  task automatic t_pattern;
    logic [31:0] d;
    reset_done = 1'b1;
    repeat (4) @(negedge clk);
    read1(1'b0, 8'h1F, d);
    check("R8 test pattern", d, PATTERN);
    read1(1'b1, 8'h05, d);
    check("R10 R1 mode3 bank read", d, expm[8'h05]);
  endtask

  task automatic t_single_write;
    logic [31:0] d;
    int c0;
    c0 = wr_cnt;
    wbuf[0] = 32'hC0DE_1234;
    spi_txn(1'b0, 8'h02, 8'h10, 1, 0);
    expm[8'h10] = 32'hC0DE_1234;
    check("R4 one strobe per word", wr_cnt - c0, 1);
    check("R7 oe low in write", hdr_oe + data_oe_hi, 0);
    read1(1'b1, 8'h10, d);
    check("R1 R10 write readback", d, expm[8'h10]);
  endtask

  task automatic t_inc_wrap;
    wbuf[0] = 32'h1111_AAAA; wbuf[1] = 32'h2222_BBBB; wbuf[2] = 32'h3333_CCCC;
    spi_txn(1'b1, 8'h06, 8'hFE, 3, 0);
    expm[8'hFE] = wbuf[0]; expm[8'hFF] = wbuf[1]; expm[8'h00] = wbuf[2];
    check("R7 oe low in burst write", hdr_oe + data_oe_hi, 0);
    spi_txn(1'b0, 8'h07, 8'hFE, 3, 0);
    check("R3 inc read FE", rbuf[0], expm[8'hFE]);
    check("R5 inc read FF", rbuf[1], expm[8'hFF]);
    check("R5 inc wrap 00", rbuf[2], expm[8'h00]);
  endtask

  task automatic t_dec_wrap;
    wbuf[0] = 32'h4444_0001; wbuf[1] = 32'h5555_0002; wbuf[2] = 32'h6666_0003;
    spi_txn(1'b0, 8'h0A, 8'h01, 3, 0);
    expm[8'h01] = wbuf[0]; expm[8'h00] = wbuf[1]; expm[8'hFF] = wbuf[2];
    spi_txn(1'b1, 8'h0B, 8'h01, 3, 0);
    check("R3 dec read 01", rbuf[0], expm[8'h01]);
    check("R3 dec read 00", rbuf[1], expm[8'h00]);
    check("R5 dec wrap FF", rbuf[2], expm[8'hFF]);
    check("R2 oe through burst", data_oe_lo, 0);
  endtask

  task automatic t_fixed;
    int c0;
    c0 = wr_cnt;
    wbuf[0] = 32'hAAAA_0000; wbuf[1] = 32'hBBBB_1111;
    spi_txn(1'b0, 8'h02, 8'h20, 2, 0);
    expm[8'h20] = wbuf[1];
    check("R4 fixed burst strobes", wr_cnt - c0, 2);
    check("R4 fixed neighbour untouched", mem[8'h21], expm[8'h21]);
    wbuf[0] = '0; wbuf[1] = '0;
    spi_txn(1'b1, 8'h03, 8'h20, 2, 0);
    check("R3 fixed read word0", rbuf[0], expm[8'h20]);
    check("R3 fixed read word1", rbuf[1], expm[8'h20]);
  endtask

  task automatic t_partial;
    logic [31:0] d;
    int c0;
    c0 = wr_cnt;
    wbuf[0] = 32'h7777_8888; wbuf[1] = 32'h9999_EEEE;
    spi_txn(1'b0, 8'h06, 8'h30, 1, 20);
    expm[8'h30] = wbuf[0];
    check("R6 only full word strobed", wr_cnt - c0, 1);
    read1(1'b0, 8'h30, d);
    check("R6 full word kept", d, expm[8'h30]);
    read1(1'b1, 8'h31, d);
    check("R6 cut word discarded", d, expm[8'h31]);
  endtask

  task automatic t_unknown;
    logic [31:0] d;
    int c0, r0;
    c0 = wr_cnt; r0 = rd_cnt;
    wbuf[0] = 32'hDEAD_BEEF;
    spi_txn(1'b0, 8'h0E, 8'h40, 1, 0);
    check("R9 no write strobe", wr_cnt - c0, 0);
    check("R9 no read request", rd_cnt - r0, 0);
    check("R9 no SO drive", hdr_oe + data_oe_hi, 0);
    read1(1'b0, 8'h40, d);
    check("R9 register unchanged", d, expm[8'h40]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) expm[i] = (i * 32'h0101_0101) ^ 32'h1357_9BDF;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_not_ready;
    t_pattern;
    t_single_write;
    t_inc_wrap;
    t_dec_wrap;
    t_fixed;
    t_partial;
    t_unknown;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule